// File: doc/BRIEF.md
# Crosstalk-Avoiding Flit Encoder

This block sits on the transmit side of an on-chip network link. It accepts the flits of a packet on a valid/ready input and drives a registered channel word toward the next router. The channel may never carry an opposite-direction transition. Such a transition is a pair of neighbouring wires where one rises while the other falls between two consecutive channel words. Three mechanisms enforce this rule.

First, the encoder holds a small buffer of pending flits and chooses which one to send next. Second, it rotates the chosen flit's bits to one of a fixed set of left-circular offsets. When no buffered flit at any offset is free of opposite-direction transitions against the previous word, the encoder sends a null word in between. The null word is the bitwise AND of the previous word and the best candidate.

Sideband fields carry what a receiver needs to undo the coding: the rotation amount, each data flit's position inside its packet, and a null marker. Buffer depth, the number of rotation offsets, the channel width and the index width are parameters.

Top module: `flit_xt_encoder`

## Requirements
- R1: Between any two consecutive words driven on `ch_data`, no pair of adjacent bits i and i+1 has one bit rising and the other falling. Adjacency does not wrap from the top bit to bit 0. The first word is compared against the all-zero reset value.
- R2: Each new channel word is selected from all buffered flits at all allowed rotations. The selection minimises the number of opposite-direction pairs against the word currently held on the channel.
- R3: A data word equals its flit rotated left circularly by `ch_rot` positions, so bit i of the flit appears at bit (i + `ch_rot`) mod width. `ch_rot` ranges from 0 to NROT-1.
- R4: Among candidates with equal counts, the lowest buffer slot wins, and within a slot the smallest rotation wins. Incoming flits fill the lowest free slot.
- R5: When the best candidate still has a nonzero count, the encoder emits a null word with `ch_null`=1, `ch_rot`=0 and `ch_seq`=0. Its data is the AND of the previous word and that rotated candidate, so it holds no bit that the previous word lacks. The flit stays buffered, the next word is selected again against the null, and two null words never follow each other.
- R6: A data word carries on `ch_seq` its flit's position in its packet. The first flit of a packet has position 0. The position counter restarts after a flit accepted with `in_last`=1.
- R7: While `ch_valid`=1 and `ch_ready`=0, all channel outputs hold. `in_ready` is low when every slot is occupied. It is also low from the cycle after a flit with `in_last`=1 is accepted until the buffer has emptied.
- R8: After reset, `ch_valid`=0, `ch_data` is all zeros and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input flit present |
| in_ready | output | 1 | Encoder can take a flit this cycle |
| in_data | input | DATA_W | Flit payload |
| in_last | input | 1 | Flit is the final one of its packet |
| ch_valid | output | 1 | Channel word valid |
| ch_ready | input | 1 | Downstream accepts the channel word |
| ch_data | output | DATA_W | Coded channel word |
| ch_rot | output | $clog2(NROT) | Left rotation applied to the data word |
| ch_seq | output | SEQ_W | Position of the flit in its packet |
| ch_null | output | 1 | Word is an inserted null |

## Verification
Null insertion and downstream backpressure can land in the same cycle: a null is loaded into the output register while `ch_ready` is low. The next selection must then wait, still measured against the held null. Random payloads make nulls frequent, and a random `ch_ready` stalls many of them. The bench checks every accepted word against the transition rule and the hold rule. Two directed packets, with the input idle, are followed word by word by a bench model of the selection, the tie order and the null formula.

// File: rtl/flit_xt_pkg.sv
`timescale 1ns/1ps
package flit_xt_pkg;

   function automatic bit fanout_ok(int v);
      return (v == 2) || (v == 4) || (v == 8);
   endfunction

   function automatic bit width_ok(int v);
      return (v == 16) || (v == 32);
   endfunction

endpackage

// File: rtl/flit_od_count.sv
`timescale 1ns/1ps
module flit_od_count #(
   parameter int DATA_W = 16,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] prev_word,
   input  logic [DATA_W-1:0] next_word,
   output logic [CNT_W-1:0]  od_cnt
);
   // a pair of neighbours switches in opposite directions when both toggle
   // and they started from different values
   always_comb begin
      od_cnt = '0;
      for (int i = 0; i < DATA_W-1; i++) begin
         if ((prev_word[i] ^ next_word[i]) && (prev_word[i+1] ^ next_word[i+1]) &&
             (prev_word[i] != prev_word[i+1]))
            od_cnt = od_cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/flit_slot_buf.sv
`timescale 1ns/1ps
module flit_slot_buf #(
   parameter int DATA_W = 16,
   parameter int NCAND  = 4,
   parameter int SEQ_W  = 4,
   localparam int SLOT_W = $clog2(NCAND)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr_en,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [SEQ_W-1:0]              wr_seq,
   input  logic                          rd_en,
   input  logic [SLOT_W-1:0]             rd_slot,
   output logic [NCAND-1:0]              slot_vld,
   output logic [NCAND-1:0][DATA_W-1:0]  slot_data,
   output logic [NCAND-1:0][SEQ_W-1:0]   slot_seq,
   output logic                          free_any
);
   logic [SLOT_W-1:0] wr_slot;

   assign free_any = ~&slot_vld;

   always_comb begin
      wr_slot = '0;
      for (int i = NCAND-1; i >= 0; i--)
         if (!slot_vld[i]) wr_slot = SLOT_W'(i);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_vld <= '0;
      end else begin
         if (rd_en) slot_vld[rd_slot] <= 1'b0;
         if (wr_en) slot_vld[wr_slot] <= 1'b1;
      end
      if (wr_en) begin
         slot_data[wr_slot] <= wr_data;
         slot_seq[wr_slot]  <= wr_seq;
      end
   end
endmodule

// File: rtl/flit_pick.sv
`timescale 1ns/1ps
module flit_pick #(
   parameter int DATA_W = 16,
   parameter int NCAND  = 4,
   parameter int NROT   = 4,
   localparam int SLOT_W = $clog2(NCAND),
   localparam int ROT_W  = $clog2(NROT),
   localparam int CNT_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]             ref_word,
   input  logic [NCAND-1:0]              slot_vld,
   input  logic [NCAND-1:0][DATA_W-1:0]  slot_data,
   output logic                          any_vld,
   output logic [SLOT_W-1:0]             best_slot,
   output logic [ROT_W-1:0]              best_rot,
   output logic [CNT_W-1:0]              best_cnt,
   output logic [DATA_W-1:0]             best_word
);
   logic [NCAND-1:0][NROT-1:0][DATA_W-1:0] cand;
   logic [NCAND-1:0][NROT-1:0][CNT_W-1:0]  cnt;

   for (genvar s = 0; s < NCAND; s++) begin : g_slot
      for (genvar r = 0; r < NROT; r++) begin : g_rot
         if (r == 0) begin : g_plain
            assign cand[s][r] = slot_data[s];
         end else begin : g_shift
            assign cand[s][r] = {slot_data[s][DATA_W-1-r:0], slot_data[s][DATA_W-1:DATA_W-r]};
         end
         flit_od_count #(.DATA_W(DATA_W)) u_od (
            .prev_word (ref_word),
            .next_word (cand[s][r]),
            .od_cnt    (cnt[s][r])
         );
      end
   end

   // strict less-than in slot-major, rotation-minor order keeps the earliest tie
   always_comb begin
      any_vld   = 1'b0;
      best_slot = '0;
      best_rot  = '0;
      best_cnt  = '0;
      best_word = '0;
      for (int s = 0; s < NCAND; s++) begin
         for (int r = 0; r < NROT; r++) begin
            if (slot_vld[s] && (!any_vld || cnt[s][r] < best_cnt)) begin
               any_vld   = 1'b1;
               best_slot = SLOT_W'(s);
               best_rot  = ROT_W'(r);
               best_cnt  = cnt[s][r];
               best_word = cand[s][r];
            end
         end
      end
   end
endmodule

// File: rtl/flit_xt_encoder.sv
`timescale 1ns/1ps
module flit_xt_encoder #(
   parameter int DATA_W = 16,
   parameter int NCAND  = 4,
   parameter int NROT   = 4,
   parameter int SEQ_W  = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [DATA_W-1:0]        in_data,
   input  logic                     in_last,
   output logic                     ch_valid,
   input  logic                     ch_ready,
   output logic [DATA_W-1:0]        ch_data,
   output logic [$clog2(NROT)-1:0]  ch_rot,
   output logic [SEQ_W-1:0]         ch_seq,
   output logic                     ch_null
);
   localparam int SLOT_W = $clog2(NCAND);
   localparam int ROT_W  = $clog2(NROT);
   localparam int CNT_W  = $clog2(DATA_W);

   if (!flit_xt_pkg::fanout_ok(NCAND)) begin : g_bad_ncand
      $error("NCAND must be 2, 4 or 8");
   end
   if (!flit_xt_pkg::fanout_ok(NROT)) begin : g_bad_nrot
      $error("NROT must be 2, 4 or 8");
   end
   if (!flit_xt_pkg::width_ok(DATA_W)) begin : g_bad_width
      $error("DATA_W must be 16 or 32");
   end
   if (SEQ_W < 1) begin : g_bad_seq
      $error("SEQ_W must be at least 1");
   end

   logic [NCAND-1:0]             slot_vld;
   logic [NCAND-1:0][DATA_W-1:0] slot_data;
   logic [NCAND-1:0][SEQ_W-1:0]  slot_seq;
   logic                         free_any;
   logic                         pick_any;
   logic [SLOT_W-1:0]            pick_slot;
   logic [ROT_W-1:0]             pick_rot;
   logic [CNT_W-1:0]             pick_cnt;
   logic [DATA_W-1:0]            pick_word;

   logic                         out_v_q;
   logic [DATA_W-1:0]            data_q;
   logic [ROT_W-1:0]             rot_q;
   logic [SEQ_W-1:0]             seq_q;
   logic                         null_q;
   logic                         closed_q;
   logic [SEQ_W-1:0]             seq_cnt_q;
   logic                         accept;
   logic                         load;
   logic                         take;

   assign in_ready = free_any && !closed_q;
   assign accept   = in_valid && in_ready;
   assign load     = (!out_v_q || ch_ready) && pick_any;
   assign take     = load && (pick_cnt == '0);

   flit_slot_buf #(.DATA_W(DATA_W), .NCAND(NCAND), .SEQ_W(SEQ_W)) u_buf (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (accept),
      .wr_data   (in_data),
      .wr_seq    (seq_cnt_q),
      .rd_en     (take),
      .rd_slot   (pick_slot),
      .slot_vld  (slot_vld),
      .slot_data (slot_data),
      .slot_seq  (slot_seq),
      .free_any  (free_any)
   );

   // the held channel word is the reference for the next selection
   flit_pick #(.DATA_W(DATA_W), .NCAND(NCAND), .NROT(NROT)) u_pick (
      .ref_word  (data_q),
      .slot_vld  (slot_vld),
      .slot_data (slot_data),
      .any_vld   (pick_any),
      .best_slot (pick_slot),
      .best_rot  (pick_rot),
      .best_cnt  (pick_cnt),
      .best_word (pick_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_v_q   <= 1'b0;
         data_q    <= '0;
         rot_q     <= '0;
         seq_q     <= '0;
         null_q    <= 1'b0;
         closed_q  <= 1'b0;
         seq_cnt_q <= '0;
      end else begin
         if (load) begin
            out_v_q <= 1'b1;
            if (take) begin
               data_q <= pick_word;
               rot_q  <= pick_rot;
               seq_q  <= slot_seq[pick_slot];
               null_q <= 1'b0;
            end else begin
               data_q <= data_q & pick_word;
               rot_q  <= '0;
               seq_q  <= '0;
               null_q <= 1'b1;
            end
         end else if (ch_ready) begin
            out_v_q <= 1'b0;
         end
         if (accept) seq_cnt_q <= in_last ? '0 : seq_cnt_q + SEQ_W'(1);
         if (accept && in_last)   closed_q <= 1'b1;
         else if (slot_vld == '0) closed_q <= 1'b0;
      end
   end

   assign ch_valid = out_v_q;
   assign ch_data  = data_q;
   assign ch_rot   = rot_q;
   assign ch_seq   = seq_q;
   assign ch_null  = null_q;
endmodule

// File: rtl/flit_xt_encoder_chk.sv
`timescale 1ns/1ps
module flit_xt_encoder_chk #(
   parameter int DATA_W = 16,
   parameter int NCAND  = 4,
   parameter int NROT   = 4,
   parameter int SEQ_W  = 4
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic                     in_ready,
   input logic                     in_last,
   input logic                     ch_valid,
   input logic                     ch_ready,
   input logic [DATA_W-1:0]        ch_data,
   input logic [$clog2(NROT)-1:0]  ch_rot,
   input logic [SEQ_W-1:0]         ch_seq,
   input logic                     ch_null
);
   function automatic int od_pairs(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
      int n = 0;
      for (int i = 0; i < DATA_W-1; i++)
         if (a[i] != b[i] && a[i+1] != b[i+1] && a[i] != a[i+1]) n++;
      return n;
   endfunction

   AST_NO_OD_STEP: assert property (@(posedge clk) disable iff (rst)
      !$stable(ch_data) |-> od_pairs($past(ch_data), ch_data) == 0); // R1

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
      ch_valid && !ch_ready |=> ch_valid && $stable(ch_data) && $stable(ch_rot) &&
                                $stable(ch_seq) && $stable(ch_null)); // R7

   AST_CLOSED_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && in_last |=> !in_ready); // R7

   AST_NULL_SIDEBAND: assert property (@(posedge clk) disable iff (rst)
      ch_valid && ch_null |-> ch_rot == '0 && ch_seq == '0); // R5

   AST_NULL_SUBSET: assert property (@(posedge clk) disable iff (rst)
      !$stable(ch_data) && ch_null |-> (ch_data & ~$past(ch_data)) == '0); // R5

   AST_NO_DOUBLE_NULL: assert property (@(posedge clk) disable iff (rst)
      ch_valid && ch_null && ch_ready |=> ch_valid && !ch_null); // R5
endmodule

bind flit_xt_encoder flit_xt_encoder_chk #(
   .DATA_W(DATA_W), .NCAND(NCAND), .NROT(NROT), .SEQ_W(SEQ_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_last  (in_last),
   .ch_valid (ch_valid),
   .ch_ready (ch_ready),
   .ch_data  (ch_data),
   .ch_rot   (ch_rot),
   .ch_seq   (ch_seq),
   .ch_null  (ch_null)
);

// File: tb/tb_flit_xt_encoder.sv
`timescale 1ns/1ps
module tb_flit_xt_encoder;
   localparam int DW = 16;
   localparam int NC = 4;
   localparam int NR = 4;
   localparam int SW = 4;
   localparam int RW = $clog2(NR);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_data = '0;
   logic          in_last = 1'b0;
   logic          ch_valid;
   logic          ch_ready = 1'b0;
   logic [DW-1:0] ch_data;
   logic [RW-1:0] ch_rot;
   logic [SW-1:0] ch_seq;
   logic          ch_null;

   int total = 0;
   int fails = 0;

   flit_xt_encoder #(.DATA_W(DW), .NCAND(NC), .NROT(NR), .SEQ_W(SW)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .ch_valid(ch_valid),
      .ch_ready(ch_ready), .ch_data(ch_data), .ch_rot(ch_rot),
      .ch_seq(ch_seq), .ch_null(ch_null)
   );

   always #2.5 clk = ~clk;

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] rotl(logic [DW-1:0] d, int r);
      logic [DW-1:0] o;
      for (int i = 0; i < DW; i++) o[(i + r) % DW] = d[i];
      return o;
   endfunction

   function automatic logic [DW-1:0] rotr(logic [DW-1:0] d, int r);
      logic [DW-1:0] o;
      for (int i = 0; i < DW; i++) o[i] = d[(i + r) % DW];
      return o;
   endfunction

   function automatic int odc(logic [DW-1:0] a, logic [DW-1:0] b);
      int n = 0;
      for (int i = 0; i < DW-1; i++)
         if (a[i] != b[i] && a[i+1] != b[i+1] && a[i] != a[i+1]) n++;
      return n;
   endfunction

   // packet store filled on acceptance
   logic [DW-1:0] pd [64][16];
   int            plen [64];
   bit            pdone [64];
   int            cur_pk = 0;

   // receive side tracking
   int            rx_pk = 0;
   int            rx_cnt = 0;
   logic [15:0]   got = '0;
   logic [DW-1:0] lastw = '0;
   int            nulls = 0;

   // selection model for directed phases
   bit            mb_v [NC];
   logic [DW-1:0] mb_d [NC];
   int            mb_s [NC];
   bit            exp_v;
   logic [DW-1:0] exp_d;
   int            exp_r;
   int            exp_s;
   bit            exp_n;

   task automatic send_flit(logic [DW-1:0] d, bit last);
      in_valid = 1'b1;
      in_data  = d;
      in_last  = last;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      pd[cur_pk][plen[cur_pk]] = d;
      plen[cur_pk]++;
      if (last) begin
         pdone[cur_pk] = 1'b1;
         cur_pk++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic model_step();
      bit found = 1'b0;
      int bs = 0, br = 0, bc = 0;
      logic [DW-1:0] bw = '0;
      for (int s = 0; s < NC; s++)
         for (int r = 0; r < NR; r++)
            if (mb_v[s] && (!found || odc(exp_d, rotl(mb_d[s], r)) < bc)) begin
               found = 1'b1; bs = s; br = r;
               bc = odc(exp_d, rotl(mb_d[s], r));
               bw = rotl(mb_d[s], r);
            end
      if (!found) begin
         exp_v = 1'b0;
      end else if (bc == 0) begin
         exp_d = bw; exp_r = br; exp_s = mb_s[bs]; exp_n = 1'b0;
         mb_v[bs] = 1'b0;
      end else begin
         exp_d = exp_d & bw; exp_r = 0; exp_s = 0; exp_n = 1'b1;
      end
   endtask

   // called at a falling edge; follows the channel word by word
   task automatic run_model(string order_tag);
      forever begin
         bit rdy;
         rdy = ($urandom % 3) != 0;
         ch_ready = rdy;
         #1;
         chk(ch_valid == exp_v, "R2", "valid", 64'(ch_valid), 64'(exp_v));
         if (!exp_v) break;
         chk(ch_data == exp_d, "R2", "selected word", 64'(ch_data), 64'(exp_d));
         chk(int'(ch_rot) == exp_r, "R3", "rotation", 64'(ch_rot), 64'(exp_r));
         chk(int'(ch_seq) == exp_s, order_tag, "sequence", 64'(ch_seq), 64'(exp_s));
         chk(ch_null == exp_n, "R5", "null flag", 64'(ch_null), 64'(exp_n));
         @(negedge clk);
         if (rdy) model_step();
      end
      @(negedge clk);
      ch_ready = 1'b0;
   endtask

   // load one packet with the channel stalled, then follow it out
   task automatic directed(logic [DW-1:0] first, logic [DW-1:0] vals [NC], string order_tag);
      ch_ready = 1'b0;
      send_flit(first, 1'b0);
      repeat (3) @(negedge clk);
      #1;
      chk(ch_valid && ch_data == first && ch_rot == '0 && ch_seq == '0 && !ch_null,
          "R4", "head word, smallest rotation", 64'(ch_data), 64'(first));
      for (int i = 0; i < NC; i++) begin
         @(negedge clk);
         send_flit(vals[i], i == NC-1);
      end
      #1;
      chk(in_ready == 1'b0, "R7", "in_ready after last", 64'(in_ready), 64'd0);
      for (int i = 0; i < NC; i++) begin
         mb_v[i] = 1'b1;
         mb_d[i] = vals[i];
         mb_s[i] = i + 1;
      end
      exp_v = 1'b1; exp_d = first; exp_r = 0; exp_s = 0; exp_n = 1'b0;
      @(negedge clk);
      run_model(order_tag);
      repeat (3) @(negedge clk);
      #1;
      chk(in_ready == 1'b1, "R7", "in_ready after drain", 64'(in_ready), 64'd1);
      @(negedge clk);
   endtask

   // channel monitor: transition rule, hold rule, content and index
   initial begin : mon
      bit            hv = 1'b0;
      logic [DW-1:0] hd = '0;
      logic [RW-1:0] hr = '0;
      logic [SW-1:0] hs = '0;
      logic          hn = 1'b0;
      logic [DW-1:0] orig;
      forever begin
         @(negedge clk);
         #1;
         if (!rst) begin
            if (hv)
               chk(ch_valid && ch_data == hd && ch_rot == hr && ch_seq == hs && ch_null == hn,
                   "R7", "hold under stall", 64'(ch_data), 64'(hd));
            hv = ch_valid && !ch_ready;
            hd = ch_data; hr = ch_rot; hs = ch_seq; hn = ch_null;
            if (ch_valid && ch_ready) begin
               chk(odc(lastw, ch_data) == 0, "R1", "opposite transitions",
                   64'(odc(lastw, ch_data)), 64'd0);
               if (ch_null) begin
                  nulls++;
                  chk((ch_data & ~lastw) == '0, "R5", "null within previous word",
                      64'(ch_data), 64'(ch_data & lastw));
               end else begin
                  orig = rotr(ch_data, int'(ch_rot));
                  chk(int'(ch_seq) < plen[rx_pk] && !got[ch_seq] && pd[rx_pk][ch_seq] == orig,
                      "R6", "restored flit at index", 64'(orig), 64'(pd[rx_pk][ch_seq]));
                  got[ch_seq] = 1'b1;
                  rx_cnt++;
                  if (pdone[rx_pk] && rx_cnt == plen[rx_pk]) begin
                     rx_pk++;
                     rx_cnt = 0;
                     got = '0;
                  end
               end
               lastw = ch_data;
            end
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   bit rnd_on = 1'b0;
   initial begin : rnd_ready
      forever begin
         @(negedge clk);
         if (rnd_on) ch_ready = ($urandom % 4) != 0;
      end
   end

   initial begin : main
      logic [DW-1:0] va [NC];
      logic [DW-1:0] vz [NC];
      logic [DW-1:0] pat [8];
      void'($urandom(32'd20240611));
      for (int i = 0; i < 64; i++) begin
         plen[i] = 0;
         pdone[i] = 1'b0;
      end
      pat[0] = 16'hF00F; pat[1] = 16'h3C3C; pat[2] = 16'h0FF0; pat[3] = 16'h5A5A;
      pat[4] = 16'h9669; pat[5] = 16'hC3A5; pat[6] = 16'h7E81; pat[7] = 16'h1248;
      for (int i = 0; i < NC; i++) begin
         va[i] = pat[i % 8];
         vz[i] = '0;
      end

      repeat (4) @(negedge clk);
      #1;
      chk(ch_valid == 1'b0, "R8", "valid in reset", 64'(ch_valid), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      #1;
      chk(ch_valid == 1'b0, "R8", "valid after reset", 64'(ch_valid), 64'd0);
      chk(ch_data == '0, "R8", "data after reset", 64'(ch_data), 64'd0);
      chk(in_ready == 1'b1, "R8", "in_ready after reset", 64'(in_ready), 64'd1);
      @(negedge clk);

      // mixed payloads: reorder, rotation and null choices against a model
      directed(16'h0F0F, va, "R6");
      // identical zero flits: every candidate ties, slot order decides
      directed(16'h0000, vz, "R4");

      // random traffic with random backpressure
      rnd_on = 1'b1;
      for (int p = 0; p < 30; p++) begin
         int len;
         len = 1 + int'($urandom % 8);
         for (int i = 0; i < len; i++) begin
            if ($urandom % 3 == 0) @(negedge clk);
            send_flit(DW'($urandom), i == len-1);
         end
      end
      while (rx_pk < cur_pk) @(negedge clk);
      repeat (4) @(negedge clk);
      rnd_on = 1'b0;
      chk(rx_pk == cur_pk, "R6", "all packets delivered", 64'(rx_pk), 64'(cur_pk));
      chk(nulls > 0, "R5", "null words seen", 64'(nulls), 64'd1);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule